// File: doc/BRIEF.md
# Strobed Debug Register Load Port

This block sits between a host debug processor and a machine under test. The host presents a 13-bit command made of a 3-bit register select, a 9-bit data value and a single strobe line. A register is written only after the host drives the strobe low, then high, then low again, with the select and data held steady. The block passes the strobe through a two-flop synchroniser and detects its falling edge. On that edge it writes the data into one of eight targets: a control register, a clock register, the two bytes of a 16-bit transfer word, or one of four 9-bit bytes of a 36-bit microinstruction store.

The microinstruction store keeps its contents when a byte is written: each byte load is ORed into what the store already holds. It is emptied only by a level clear bit in the control register, which keeps clearing for as long as it stays set. The 36 stored bits are held in a scrambled order. The block rearranges them into a 34-bit instruction followed by two odd-parity bits, and raises a separate error flag for each half of the instruction whose parity is wrong. The control and clock register contents are presented as plain output bits for the rest of the machine.

Top module: `dbg_strobe_port`

## Requirements
- R1: While reset is asserted and after it is released, the control, clock, transfer and microinstruction outputs are all zero. Both parity error flags are therefore 1, because an all-zero half has even parity.
- R2: Exactly one write happens for each completed strobe pulse, at the falling edge of the strobe. While the strobe is held high nothing changes. Outputs have settled no later than 6 clock cycles after the strobe falls, provided select and data are held until then.
- R3: The select value decides the target. 0 writes the control register (all 9 data bits). 1 writes the clock register (all 9 bits). 2 writes data[7:0] into transfer bits [15:8]. 3 writes data[7:0] into transfer bits [7:0]. Data bit 8 has no effect on the transfer word. A write to one target leaves every other target unchanged.
- R4: Selects 4, 5, 6 and 7 OR the 9 data bits into microinstruction bytes 0, 1, 2 and 3 respectively. Bits that are already set stay set.
- R5: While control bit 7 is 1, the microinstruction store is held at zero, and byte loads made during that time are lost. The clear takes priority over a byte load in the same cycle.
- R6: The instruction output is built from the bytes (bits numbered 0..8, byte j written b_j) in this order. Bit 0 is b0[8]. Bits 1+4j+k are b_j[k] and bits 17+4j+k are b_j[4+k], for j and k each from 0 to 3. Bit 33 is b2[8]. The first parity bit is b1[8] and the second parity bit is b3[8].
- R7: The first error flag is 1 exactly when instruction bits 0..16 together with the first parity bit hold an even number of ones. The second error flag applies the same rule to bits 17..33 with the second parity bit.
- R8: A second pulse to the same select may begin directly at the high phase, right after the previous low phase, with new data. The second pulse writes its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 3 | Register select from the host |
| host_data | input | 9 | Data value from the host |
| host_strobe | input | 1 | Host strobe line, asynchronous |
| ctrl_bits | output | 9 | Control register contents |
| clkreg_bits | output | 9 | Clock register contents |
| xfer_word | output | 16 | Transfer word |
| insn_word | output | 34 | Unscrambled instruction |
| perr_first | output | 1 | Odd-parity error, instruction bits 0..16 |
| perr_second | output | 1 | Odd-parity error, instruction bits 17..33 |

## Verification
The level clear and a microinstruction byte load can act in the same cycle. The clear stays set in the control register while the host strobes further byte writes. The bench provokes this by setting the clear bit on purpose, and also by random control writes that set it about a quarter of the time, mixed with random byte loads. It judges the result by checking that the assembled instruction stays zero and that the parity flags stay high until the clear bit is written back to 0. Only byte loads made after that point may show up in the instruction.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;
  localparam int SEL_W     = 3;
  localparam int DATA_W    = 9;
  localparam int NBYTES    = 4;
  localparam int STORE_W   = DATA_W * NBYTES;
  localparam int INSN_W    = STORE_W - 2;
  localparam int HALF_W    = INSN_W / 2;
  localparam int XFER_W    = 16;
  localparam int XBYTE_W   = XFER_W / 2;
  localparam int NIB_W     = 4;
  localparam int CLR_STORE_BIT = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_CLK  = 3'd1,
    SEL_XHI  = 3'd2,
    SEL_XLO  = 3'd3,
    SEL_B0   = 3'd4,
    SEL_B1   = 3'd5,
    SEL_B2   = 3'd6,
    SEL_B3   = 3'd7
  } sel_e;

  typedef logic [NBYTES-1:0][DATA_W-1:0] store_t;

  // Rearrange the stored bytes into instruction order; bits 34/35 are parity.
  function automatic logic [STORE_W-1:0] unscramble(input store_t b);
    logic [STORE_W-1:0] u;
    u = '0;
    u[0] = b[0][DATA_W-1];
    for (int j = 0; j < NBYTES; j++) begin
      for (int k = 0; k < NIB_W; k++) begin
        u[1 + NIB_W*j + k]      = b[j][k];
        u[HALF_W + NIB_W*j + k] = b[j][NIB_W + k];
      end
    end
    u[INSN_W-1] = b[2][DATA_W-1];
    u[INSN_W]   = b[1][DATA_W-1];
    u[INSN_W+1] = b[3][DATA_W-1];
    return u;
  endfunction
endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dp_strobe_sync.sv
module dp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fire_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;
  logic              settled;

  assign settled = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], strobe_i};
    last_d = settled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  // Completion of the 0-1-0 sequence: synchronised strobe falls.
  assign fire_o = last_q & ~settled;

  p_single_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/dp_reg_bank.sv
module dp_reg_bank
  import dbgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] clk_o,
  output logic [XFER_W-1:0] xfer_o,
  output logic [NBYTES-1:0] store_we_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, clk_q, clk_d;
  logic [XFER_W-1:0] xfer_q, xfer_d;
  logic              ctrl_en, clk_en;
  logic [1:0]        xbyte_en;
  sel_e              sel;

  assign sel = sel_e'(sel_i);

  always_comb begin
    ctrl_en  = fire_i && (sel == SEL_CTRL);
    clk_en   = fire_i && (sel == SEL_CLK);
    xbyte_en = {fire_i && (sel == SEL_XHI), fire_i && (sel == SEL_XLO)};
    ctrl_d   = ctrl_en ? data_i : ctrl_q;
    clk_d    = clk_en  ? data_i : clk_q;
  end

  for (genvar h = 0; h < 2; h++) begin : g_xbyte
    always_comb begin
      xfer_d[h*XBYTE_W +: XBYTE_W] = xbyte_en[h] ? data_i[XBYTE_W-1:0]
                                                 : xfer_q[h*XBYTE_W +: XBYTE_W];
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_we
    assign store_we_o[i] = fire_i && (sel_i == SEL_W'(NBYTES + i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      clk_q  <= '0;
      xfer_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      clk_q  <= clk_d;
      xfer_q <= xfer_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign clk_o  = clk_q;
  assign xfer_o = xfer_q;

  p_hold_without_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> ($stable(ctrl_q) && $stable(clk_q) && $stable(xfer_q)));

  p_xfer_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && sel_i == SEL_XHI) |=>
      (xfer_q[XFER_W-1:XBYTE_W] == $past(data_i[XBYTE_W-1:0])) && $stable(ctrl_q));
endmodule

// File: rtl/dp_insn_store.sv
module dp_insn_store
  import dbgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic [INSN_W-1:0] insn_o,
  output logic              perr_first_o,
  output logic              perr_second_o
);
  store_t             bytes_q, bytes_d;
  logic [NBYTES-1:0]  en;
  logic [STORE_W-1:0] flat;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_comb begin
      en[i] = clr_i | we_i[i];
      if (clr_i)         bytes_d[i] = '0;
      else if (we_i[i])  bytes_d[i] = bytes_q[i] | data_i;
      else               bytes_d[i] = bytes_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bytes_q[i] <= '0;
      else if (en[i]) bytes_q[i] <= bytes_d[i];
    end

    p_or_keeps_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((bytes_q[i] & $past(bytes_q[i])) == $past(bytes_q[i])));
  end

  always_comb begin
    flat          = unscramble(bytes_q);
    insn_o        = flat[INSN_W-1:0];
    perr_first_o  = ~(^{flat[HALF_W-1:0], flat[INSN_W]});
    perr_second_o = ~(^{flat[INSN_W-1:HALF_W], flat[INSN_W+1]});
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (insn_o == '0) && perr_first_o && perr_second_o);
endmodule

// File: rtl/dbg_strobe_port.sv
module dbg_strobe_port
  import dbgport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_sel,
  input  logic [8:0]  host_data,
  input  logic        host_strobe,
  output logic [8:0]  ctrl_bits,
  output logic [8:0]  clkreg_bits,
  output logic [15:0] xfer_word,
  output logic [33:0] insn_word,
  output logic        perr_first,
  output logic        perr_second
);
  logic              rst_n_int;
  logic              fire;
  logic [NBYTES-1:0] store_we;

  dp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dp_strobe_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .strobe_i (host_strobe),
    .fire_o   (fire)
  );

  dp_reg_bank u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .fire_i     (fire),
    .sel_i      (host_sel),
    .data_i     (host_data),
    .ctrl_o     (ctrl_bits),
    .clk_o      (clkreg_bits),
    .xfer_o     (xfer_word),
    .store_we_o (store_we)
  );

  dp_insn_store u_store (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .we_i          (store_we),
    .data_i        (host_data),
    .clr_i         (ctrl_bits[CLR_STORE_BIT]),
    .insn_o        (insn_word),
    .perr_first_o  (perr_first),
    .perr_second_o (perr_second)
  );

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n_int |-> (ctrl_bits == '0 && xfer_word == '0 && insn_word == '0));
endmodule

// File: tb/sim_dbg_strobe_port.sv
`timescale 1ns/1ps
module sim_dbg_strobe_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sel;
  logic [8:0]  data;
  logic        strobe;
  logic [8:0]  ctrl_bits, clkreg_bits;
  logic [15:0] xfer_word;
  logic [33:0] insn_word;
  logic        perr_first, perr_second;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [8:0]  m_ctrl, m_clk;
  logic [15:0] m_xfer;
  logic [8:0]  m_b [4];

  always #2.5 clk = ~clk;

  dbg_strobe_port u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_data(data),
    .host_strobe(strobe), .ctrl_bits(ctrl_bits), .clkreg_bits(clkreg_bits),
    .xfer_word(xfer_word), .insn_word(insn_word),
    .perr_first(perr_first), .perr_second(perr_second)
  );

  function automatic logic [35:0] ref_order();
    logic [35:0] u;
    u[0] = m_b[0][8];
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < 4; k++) begin
        u[1 + 4*j + k]  = m_b[j][k];
        u[17 + 4*j + k] = m_b[j][4 + k];
      end
    u[33] = m_b[2][8];
    u[34] = m_b[1][8];
    u[35] = m_b[3][8];
    return u;
  endfunction

  function automatic logic ref_perr(input logic [16:0] half, input logic p);
    int ones = 0;
    for (int i = 0; i < 17; i++) ones += int'(half[i]);
    ones += int'(p);
    return (ones % 2) == 0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [35:0] u;
    u = ref_order();
    check(req, "ctrl", 36'(ctrl_bits), 36'(m_ctrl));
    check(req, "clkreg", 36'(clkreg_bits), 36'(m_clk));
    check(req, "xfer", 36'(xfer_word), 36'(m_xfer));
    check(req, "insn", 36'(insn_word), 36'(u[33:0]));
    check(req, "perr_first", 36'(perr_first), 36'(ref_perr(u[16:0], u[34])));
    check(req, "perr_second", 36'(perr_second), 36'(ref_perr(u[33:17], u[35])));
  endtask

  task automatic model_write(input logic [2:0] a, input logic [8:0] d);
    case (a)
      3'd0: m_ctrl = d;
      3'd1: m_clk = d;
      3'd2: m_xfer[15:8] = d[7:0];
      3'd3: m_xfer[7:0] = d[7:0];
      default: if (!m_ctrl[7]) m_b[a - 3'd4] = m_b[a - 3'd4] | d;
    endcase
    if (m_ctrl[7]) for (int i = 0; i < 4; i++) m_b[i] = '0;
  endtask

  task automatic drive(input logic [2:0] a, input logic [8:0] d,
                       input logic s, input int n);
    @(negedge clk);
    sel = a; data = d; strobe = s;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] a, input logic [8:0] d);
    drive(a, d, 1'b0, 2);
    drive(a, d, 1'b1, 3);
    drive(a, d, 1'b0, 7);
    model_write(a, d);
  endtask

  task automatic pulse_short(input logic [2:0] a, input logic [8:0] d);
    drive(a, d, 1'b1, 3);
    drive(a, d, 1'b0, 7);
    model_write(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1979));
    rst_n = 1'b0; sel = '0; data = '0; strobe = 1'b0;
    m_ctrl = '0; m_clk = '0; m_xfer = '0;
    for (int i = 0; i < 4; i++) m_b[i] = '0;
    repeat (4) @(negedge clk);
    check_all("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R3: each target on its own, bit 8 ignored for transfer bytes
    pulse(3'd0, 9'h155); check_all("R3");
    pulse(3'd1, 9'h0AA); check_all("R3");
    pulse(3'd2, 9'h1C3); check_all("R3");
    pulse(3'd3, 9'h13C); check_all("R3");
    pulse(3'd0, 9'h000); check_all("R3");

    // R2: strobe held high writes nothing until it falls
    drive(3'd3, 9'h05A, 1'b0, 2);
    drive(3'd3, 9'h05A, 1'b1, 12);
    check_all("R2");
    drive(3'd3, 9'h05A, 1'b0, 7);
    model_write(3'd3, 9'h05A);
    check_all("R2");

    // R8: overlapped pulses to the same select
    pulse(3'd2, 9'h011); check_all("R8");
    pulse_short(3'd2, 9'h0EE); check_all("R8");
    pulse_short(3'd2, 9'h07F); check_all("R8");

    // R6 and R7: single bits through the reordering
    pulse(3'd6, 9'h100); check_all("R6");
    pulse(3'd5, 9'h100); check_all("R7");
    pulse(3'd7, 9'h100); check_all("R7");
    pulse(3'd4, 9'h101); check_all("R6");
    // R4: OR accumulation
    pulse(3'd4, 9'h0F0); check_all("R4");
    pulse(3'd4, 9'h00E); check_all("R4");

    // R5: clear set, then byte loads during clear are lost
    pulse(3'd0, 9'h080); check_all("R5");
    pulse(3'd5, 9'h1FF); check_all("R5");
    pulse(3'd7, 9'h0FF); check_all("R5");
    pulse(3'd0, 9'h000);
    pulse(3'd7, 9'h011); check_all("R5");

    // Random mix
    for (int it = 0; it < 90; it++) begin
      logic [2:0] a;
      logic [8:0] d;
      a = 3'($urandom_range(0, 7));
      d = 9'($urandom);
      if (a == 3'd0) d[7] = ($urandom_range(0, 3) == 0);
      if (($urandom_range(0, 2) == 0) && it > 0) pulse_short(sel, d);
      else pulse(a, d);
      check_all((a >= 3'd4) ? "R4" : "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule